// File: doc/BRIEF.md
# Sampled Polling Interrupt Vector Controller

This block gathers eleven interrupt sources and presents one pending request to a processor core as a request line plus a fixed 16-bit vector address. The sources are two external pins, two timer overflows, two DMA completion flags, a plain serial port flag, and four requests from a buffered serial channel. The serial channel's receive-valid and transmit-valid requests each come from one of two flags. A single DMA mode bit picks between the FIFO-status flag and the operation-done flag. The channel's receive-error and transmit-error requests are each the OR of a group of error condition bits.

All source flags are captured into a snapshot on the clock edge where the machine-cycle phase strobe is high. On the following clock edge the snapshot is scanned in a fixed polling order, within two priority levels. A selected request is held until the core acknowledges it. While a request is in service, requests of the same or lower level are blocked. The block stays in this state until the core signals a return from interrupt.

Top module: `intc_vector_ctl`

## Requirements
- R1: With `dma_mode`=0, the receive-valid source follows `rx_fifo_ne` and the transmit-valid source follows `tx_fifo_nf`; `rx_done` and `tx_done` are ignored.
- R2: With `dma_mode`=1, the receive-valid source follows `rx_done` and the transmit-valid source follows `tx_done`; the FIFO flags are ignored.
- R3: The receive-error source is active when any bit of `rx_err` is 1. The transmit-error source is active when any bit of `tx_err` is 1.
- R4: Flags are captured only on a clock edge with `sample_stb`=1. A flag raised after that edge has no effect until the next strobe edge.
- R5: `irq_req` rises on the second clock edge counted from the strobe edge (the poll edge), and not before.
- R6: Polling order, with enable index and vector: 0 ext0 0x0003, 1 receive valid 0x002B, 2 timer 0 0x000B, 3 receive error 0x0033, 4 DMA 0 0x003B, 5 ext1 0x0013, 6 transmit valid 0x0043, 7 timer 1 0x001B, 8 transmit error 0x004B, 9 DMA 1 0x0053, 10 serial port 0x0023. Among same-level requests, the lowest index wins.
- R7: Setting `src_pri[i]`=1 makes source i high level. An eligible high-level request beats every low-level one, whatever its index.
- R8: A source requests only when its bit in `src_en` is 1 and `glob_en` is 1.
- R9: Once raised, `irq_req` and `irq_vec` stay stable until `irq_ack`. `irq_req` falls on the edge where `irq_ack` is seen.
- R10: An acknowledged request puts its level in service. A high level in service blocks all requests. A low level in service blocks low requests only. Each `irq_ret` pulse ends the highest level in service.
- R11: After reset, `irq_req` is 0, `irq_vec` is 0, and no level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext0 | input | 1 | External request 0 |
| ext1 | input | 1 | External request 1 |
| tmr0_ovf | input | 1 | Timer 0 overflow flag |
| tmr1_ovf | input | 1 | Timer 1 overflow flag |
| dma0_done | input | 1 | DMA channel 0 done flag |
| dma1_done | input | 1 | DMA channel 1 done flag |
| ser_flag | input | 1 | Plain serial port flag |
| rx_fifo_ne | input | 1 | Receive FIFO not empty |
| rx_done | input | 1 | Receive operation done |
| tx_fifo_nf | input | 1 | Transmit FIFO not full |
| tx_done | input | 1 | Transmit operation done |
| rx_err | input | N_RX_ERR | Receive error conditions |
| tx_err | input | N_TX_ERR | Transmit error conditions |
| dma_mode | input | 1 | Valid-source select for the serial channel |
| glob_en | input | 1 | Global enable |
| src_en | input | 11 | Per-source enables, by polling index |
| src_pri | input | 11 | Per-source level, 1 = high |
| sample_stb | input | 1 | Machine-cycle sampling phase strobe |
| irq_ack | input | 1 | Core accepts the request |
| irq_ret | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 16 | Vector address of the request |

## Verification
The bench builds the block with three receive error bits and two transmit error bits. This lets it trigger the error sources from a bit other than bit 0, which shows that the whole group is ORed and not only the lowest bit. At these widths the bench reaches every index of the polling table. It also reaches both mode-bit paths for the two valid sources, and both combinations of levels in service.

// File: rtl/intc_vec_pkg.sv
package intc_vec_pkg;
  localparam int NUM_SRC = 11;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int VEC_W   = 16;

  typedef enum logic [IDX_W-1:0] {
    S_EXT0 = 4'd0, S_RXV = 4'd1, S_TMR0 = 4'd2, S_RXE = 4'd3,
    S_DMA0 = 4'd4, S_EXT1 = 4'd5, S_TXV = 4'd6, S_TMR1 = 4'd7,
    S_TXE  = 4'd8, S_DMA1 = 4'd9, S_SER = 4'd10
  } src_e;

  // Fixed vector per polling slot.
  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    case (idx)
      S_EXT0:  vec_of = 16'h0003;
      S_RXV:   vec_of = 16'h002B;
      S_TMR0:  vec_of = 16'h000B;
      S_RXE:   vec_of = 16'h0033;
      S_DMA0:  vec_of = 16'h003B;
      S_EXT1:  vec_of = 16'h0013;
      S_TXV:   vec_of = 16'h0043;
      S_TMR1:  vec_of = 16'h001B;
      S_TXE:   vec_of = 16'h004B;
      S_DMA1:  vec_of = 16'h0053;
      S_SER:   vec_of = 16'h0023;
      default: vec_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/intc_sampler.sv
module intc_sampler
  import intc_vec_pkg::*;
#(
  parameter int N_RX_ERR = 3,
  parameter int N_TX_ERR = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ext0,
  input  logic                ext1,
  input  logic                tmr0_ovf,
  input  logic                tmr1_ovf,
  input  logic                dma0_done,
  input  logic                dma1_done,
  input  logic                ser_flag,
  input  logic                rx_fifo_ne,
  input  logic                rx_done,
  input  logic                tx_fifo_nf,
  input  logic                tx_done,
  input  logic [N_RX_ERR-1:0] rx_err,
  input  logic [N_TX_ERR-1:0] tx_err,
  input  logic                dma_mode,
  input  logic                sample_stb,
  output logic [NUM_SRC-1:0]  snap,
  output logic                poll
);
  logic [NUM_SRC-1:0] raw;

  always_comb begin
    raw         = '0;
    raw[S_EXT0] = ext0;
    raw[S_RXV]  = dma_mode ? rx_done : rx_fifo_ne;
    raw[S_TMR0] = tmr0_ovf;
    raw[S_RXE]  = |rx_err;
    raw[S_DMA0] = dma0_done;
    raw[S_EXT1] = ext1;
    raw[S_TXV]  = dma_mode ? tx_done : tx_fifo_nf;
    raw[S_TMR1] = tmr1_ovf;
    raw[S_TXE]  = |tx_err;
    raw[S_DMA1] = dma1_done;
    raw[S_SER]  = ser_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap <= '0;
      poll <= 1'b0;
    end else begin
      poll <= sample_stb;
      if (sample_stb) snap <= raw;
    end
  end
endmodule

// File: rtl/intc_poll_arb.sv
module intc_poll_arb
  import intc_vec_pkg::*;
(
  input  logic [NUM_SRC-1:0] snap,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] src_pri,
  input  logic               glob_en,
  input  logic               poll,
  input  logic               blk_hi,
  input  logic               blk_lo,
  output logic               win_vld,
  output logic [IDX_W-1:0]   win_idx,
  output logic               win_hi
);
  logic [NUM_SRC-1:0] live, hi_m, lo_m;
  logic [IDX_W-1:0]   hi_idx, lo_idx;

  assign live = snap & src_en & {NUM_SRC{glob_en}};
  assign hi_m = live & src_pri;
  assign lo_m = live & ~src_pri;

  // Scan from the end so the earliest slot is the last to assign.
  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hi_m[i]) hi_idx = IDX_W'(i);
      if (lo_m[i]) lo_idx = IDX_W'(i);
    end
  end

  always_comb begin
    win_vld = 1'b0;
    win_hi  = 1'b0;
    win_idx = lo_idx;
    if (poll && !blk_hi) begin
      if (|hi_m) begin
        win_vld = 1'b1;
        win_hi  = 1'b1;
        win_idx = hi_idx;
      end else if (|lo_m && !blk_lo) begin
        win_vld = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_vector_ctl.sv
module intc_vector_ctl
  import intc_vec_pkg::*;
#(
  parameter int N_RX_ERR = 3,
  parameter int N_TX_ERR = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ext0,
  input  logic                ext1,
  input  logic                tmr0_ovf,
  input  logic                tmr1_ovf,
  input  logic                dma0_done,
  input  logic                dma1_done,
  input  logic                ser_flag,
  input  logic                rx_fifo_ne,
  input  logic                rx_done,
  input  logic                tx_fifo_nf,
  input  logic                tx_done,
  input  logic [N_RX_ERR-1:0] rx_err,
  input  logic [N_TX_ERR-1:0] tx_err,
  input  logic                dma_mode,
  input  logic                glob_en,
  input  logic [10:0]         src_en,
  input  logic [10:0]         src_pri,
  input  logic                sample_stb,
  input  logic                irq_ack,
  input  logic                irq_ret,
  output logic                irq_req,
  output logic [15:0]         irq_vec
);
  logic [NUM_SRC-1:0] snap;
  logic               poll;
  logic               win_vld, win_hi;
  logic [IDX_W-1:0]   win_idx;
  logic               cur_hi, ins_hi, ins_lo;

  intc_sampler #(.N_RX_ERR(N_RX_ERR), .N_TX_ERR(N_TX_ERR)) u_smp (
    .clk(clk), .rst(rst), .ext0(ext0), .ext1(ext1),
    .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
    .dma0_done(dma0_done), .dma1_done(dma1_done), .ser_flag(ser_flag),
    .rx_fifo_ne(rx_fifo_ne), .rx_done(rx_done),
    .tx_fifo_nf(tx_fifo_nf), .tx_done(tx_done),
    .rx_err(rx_err), .tx_err(tx_err), .dma_mode(dma_mode),
    .sample_stb(sample_stb), .snap(snap), .poll(poll)
  );

  intc_poll_arb u_arb (
    .snap(snap), .src_en(src_en), .src_pri(src_pri), .glob_en(glob_en),
    .poll(poll), .blk_hi(ins_hi), .blk_lo(ins_lo),
    .win_vld(win_vld), .win_idx(win_idx), .win_hi(win_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      cur_hi  <= 1'b0;
      ins_hi  <= 1'b0;
      ins_lo  <= 1'b0;
    end else begin
      if (irq_ret) begin
        if (ins_hi) ins_hi <= 1'b0;
        else        ins_lo <= 1'b0;
      end
      if (irq_req && irq_ack) begin
        irq_req <= 1'b0;
        if (cur_hi) ins_hi <= 1'b1;
        else        ins_lo <= 1'b1;
      end else if (!irq_req && win_vld) begin
        irq_req <= 1'b1;
        irq_vec <= vec_of(win_idx);
        cur_hi  <= win_hi;
      end
    end
  end
endmodule

// File: rtl/intc_vector_ctl_chk.sv
module intc_vector_ctl_chk (
  input logic        clk,
  input logic        rst,
  input logic        sample_stb,
  input logic        glob_en,
  input logic        irq_ack,
  input logic        irq_ret,
  input logic        irq_req,
  input logic [15:0] irq_vec,
  input logic        ins_hi
);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    irq_req && !irq_ack |=> irq_req && $stable(irq_vec));

  a_r9_ack_drops: assert property (@(posedge clk) disable iff (rst)
    irq_req && irq_ack |=> !irq_req);

  a_r5_after_poll: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(sample_stb, 2));

  a_r8_glob: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(glob_en));

  a_r6_vec_table: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec[2:0] == 3'd3 && irq_vec <= 16'h0053));

  a_r10_hi_blocks: assert property (@(posedge clk) disable iff (rst)
    ins_hi && !irq_req && !irq_ret |=> !irq_req);
endmodule

bind intc_vector_ctl intc_vector_ctl_chk u_chk (
  .clk(clk), .rst(rst), .sample_stb(sample_stb), .glob_en(glob_en),
  .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
  .irq_vec(irq_vec), .ins_hi(ins_hi)
);

// File: tb/tb_intc_vector_ctl.sv
`timescale 1ns/1ps
module tb_intc_vector_ctl;
  localparam int NRX = 3;
  localparam int NTX = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [10:0] f = '0;
  logic rx_done_r = 0, tx_done_r = 0;
  logic [NRX-1:0] rxe_x = '0;
  logic [NTX-1:0] txe_x = '0;
  logic dma_mode = 0, glob_en = 1, stb = 0, ack = 0, ret = 0;
  logic [10:0] en = '1, pri = '0;
  logic irq_req;
  logic [15:0] irq_vec;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  intc_vector_ctl #(.N_RX_ERR(NRX), .N_TX_ERR(NTX)) dut (
    .clk(clk), .rst(rst), .ext0(f[0]), .ext1(f[5]),
    .tmr0_ovf(f[2]), .tmr1_ovf(f[7]), .dma0_done(f[4]), .dma1_done(f[9]),
    .ser_flag(f[10]), .rx_fifo_ne(f[1]), .rx_done(rx_done_r),
    .tx_fifo_nf(f[6]), .tx_done(tx_done_r),
    .rx_err(rxe_x | {{(NRX-1){1'b0}}, f[3]}),
    .tx_err(txe_x | {{(NTX-1){1'b0}}, f[8]}),
    .dma_mode(dma_mode), .glob_en(glob_en), .src_en(en), .src_pri(pri),
    .sample_stb(stb), .irq_ack(ack), .irq_ret(ret),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poll();
    @(negedge clk) stb = 1;
    @(negedge clk) stb = 0;
    @(negedge clk);
  endtask

  task automatic service();
    @(negedge clk) ack = 1;
    @(negedge clk) ack = 0;
    chk("R9 ack drops req", 16'(irq_req), 16'd0);
    @(negedge clk) ret = 1;
    @(negedge clk) ret = 0;
  endtask

  task automatic t_reset();
    chk("R11 req after reset", 16'(irq_req), 16'd0);
    chk("R11 vec after reset", irq_vec, 16'h0000);
  endtask

  task automatic t_mode();
    f[1] = 1; poll();
    chk("R1 rx fifo req", 16'(irq_req), 16'd1);
    chk("R1 rx fifo vec", irq_vec, 16'h002B);
    service(); f[1] = 0;
    rx_done_r = 1; poll();
    chk("R1 rx_done ignored", 16'(irq_req), 16'd0);
    dma_mode = 1; poll();
    chk("R2 rx_done vec", irq_vec, 16'h002B);
    service(); rx_done_r = 0;
    f[6] = 1; poll();
    chk("R2 tx fifo ignored", 16'(irq_req), 16'd0);
    tx_done_r = 1; poll();
    chk("R2 tx_done vec", irq_vec, 16'h0043);
    service(); tx_done_r = 0;
    dma_mode = 0; poll();
    chk("R1 tx fifo vec", irq_vec, 16'h0043);
    service(); f[6] = 0;
  endtask

  task automatic t_err();
    rxe_x = 3'b100; poll();
    chk("R3 rx err vec", irq_vec, 16'h0033);
    service(); rxe_x = '0;
    txe_x = 2'b10; poll();
    chk("R3 tx err vec", irq_vec, 16'h004B);
    service(); txe_x = '0;
  endtask

  task automatic t_timing();
    f[5] = 1;
    @(negedge clk) stb = 1;
    @(negedge clk) stb = 0;
    chk("R5 not before poll", 16'(irq_req), 16'd0);
    @(negedge clk);
    chk("R5 at poll edge", irq_vec, 16'h0013);
    service(); f[5] = 0;
    @(negedge clk) stb = 1;
    @(negedge clk) stb = 0; f[0] = 1;
    @(negedge clk);
    chk("R4 late flag unseen", 16'(irq_req), 16'd0);
    poll();
    chk("R4 seen next strobe", irq_vec, 16'h0003);
    service(); f[0] = 0;
  endtask

  task automatic t_enable();
    f[0] = 1; en[0] = 0; poll();
    chk("R8 source disabled", 16'(irq_req), 16'd0);
    en[0] = 1; glob_en = 0; poll();
    chk("R8 global disabled", 16'(irq_req), 16'd0);
    glob_en = 1; poll();
    chk("R8 enabled", irq_vec, 16'h0003);
    f[0] = 0;
    repeat (3) @(negedge clk);
    chk("R9 held without ack", irq_vec, 16'h0003);
    chk("R9 req held", 16'(irq_req), 16'd1);
    service();
  endtask

  task automatic t_order();
    logic [15:0] exp [11] = '{16'h0003, 16'h002B, 16'h000B, 16'h0033, 16'h003B,
                              16'h0013, 16'h0043, 16'h001B, 16'h004B, 16'h0053, 16'h0023};
    f = '1;
    for (int k = 0; k < 11; k++) begin
      poll();
      chk($sformatf("R6 slot %0d", k), irq_vec, exp[k]);
      service();
      f[k] = 1'b0;
    end
  endtask

  task automatic t_prio();
    f[1] = 1; f[9] = 1; poll();
    chk("R6 low tie", irq_vec, 16'h002B);
    service();
    pri[9] = 1; poll();
    chk("R7 high override", irq_vec, 16'h0053);
    service();
    f[1] = 0; f[9] = 0; pri = '0;
  endtask

  task automatic t_nest();
    f[0] = 1; poll();
    chk("R10 low taken", irq_vec, 16'h0003);
    @(negedge clk) ack = 1;
    @(negedge clk) ack = 0; f[0] = 0; f[2] = 1;
    poll();
    chk("R10 low blocks low", 16'(irq_req), 16'd0);
    f[7] = 1; pri[7] = 1; poll();
    chk("R10 high nests", irq_vec, 16'h001B);
    @(negedge clk) ack = 1;
    @(negedge clk) ack = 0; f[7] = 0;
    @(negedge clk) ret = 1;
    @(negedge clk) ret = 0;
    poll();
    chk("R10 low still in service", 16'(irq_req), 16'd0);
    @(negedge clk) ret = 1;
    @(negedge clk) ret = 0;
    poll();
    chk("R10 low after return", irq_vec, 16'h000B);
    service(); f[2] = 0; pri = '0;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_mode();
    t_err();
    t_timing();
    t_enable();
    t_order();
    t_prio();
    t_nest();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule